// File: doc/BRIEF.md
# Weighted Pseudo-Random Pattern Generator

This block produces test stimulus vectors in which each bit is 1 with a chosen probability rather than always one half. A maximal-length linear feedback shift register supplies unbiased random bits. Each output bit takes its own group of four register bits. A two-bit weight code picks how many of those bits are ANDed together, and an invert bit may complement the result. This gives a probability of 1 equal to 1/2, 1/4, 1/8 or 1/16, or one minus any of these.

The per-bit codes and invert bits are grouped into a small bank of weight sets. Each set is written in one cycle and selected by an index input, so a test program can switch biasing between patterns without disturbing the random sequence. A nonzero seed can be loaded at any time. A pattern counter stops generation once a programmed number of patterns has been issued.

Top module: `wprpg_gen`

## Requirements
- R1: While reset is low and just after it, `pattern` is 0, `pat_valid` is 0 and `done` is 0. The random register holds the parameter `RESET_SEED` (default 32'h0000_0001). Every stored weight set holds code 00 with invert 0 for all bits.
- R2: The random state S (default 32 bits) advances by exactly one step per pattern generated and never in any other cycle. One step is S' = (S >> 1) XOR (S[0] ? TAPS : 0), with default TAPS 32'h8020_0003. The state is never all zeros.
- R3: In a cycle with `seed_load` high, no pattern is generated. A nonzero `seed` replaces the state and clears the pattern count. An all-zero `seed` is ignored and leaves the state and the count unchanged.
- R4: A cycle with `en` high, `seed_load` low and `done` low generates a pattern. In the following cycle `pat_valid` is 1 and `pattern` holds the result. Output bit i with code k (0 to 3) is the AND of state bits 4i through 4i+k, taken from the state before the step.
- R5: With invert bit i set, output bit i is the complement of that AND. Code 00 therefore stays at probability 1/2 either way, and codes 01, 10 and 11 give 3/4, 7/8 and 15/16.
- R6: There are `NUM_SETS` weight sets (default 3). A write with `cfg_we` high stores `cfg_code` and `cfg_inv` into set `cfg_set`, with the code of bit i in `cfg_code[2i+1:2i]` and its invert in `cfg_inv[i]`. A write to an index of `NUM_SETS` or above changes no set.
- R7: The set named by `set_sel` in a generating cycle shapes that pattern. A change of `set_sel` takes effect on the next pattern and does not reset the random state. An index of `NUM_SETS` or above selects set 0.
- R8: With `pat_limit` nonzero, `done` is 1 once the count of patterns since the last seed load reaches `pat_limit`. While `done` is 1, `en` has no effect and the state holds. Raising `pat_limit` resumes the sequence where it stopped.
- R9: With `pat_limit` equal to 0, `done` stays 0 and generation is unbounded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Request one pattern this cycle |
| seed_load | input | 1 | Load `seed` into the random state |
| seed | input | LFSR_W | Seed value, must be nonzero to take effect |
| cfg_we | input | 1 | Write one weight set |
| cfg_set | input | SEL_W | Index of the set being written |
| cfg_code | input | 2*PAT_W | Two-bit weight codes, bit i at [2i+1:2i] |
| cfg_inv | input | PAT_W | Invert bits, one per output bit |
| set_sel | input | SEL_W | Weight set used for generation |
| pat_limit | input | CNT_W | Patterns per run, 0 for unbounded |
| pattern | output | PAT_W | Biased test pattern |
| pat_valid | output | 1 | `pattern` was produced in the last cycle |
| done | output | 1 | Programmed pattern count reached |

## Verification
Some properties are checked on every cycle. The random state is never zero. A valid pattern always follows a request and always coincides with a state step. A seed cycle either loads the seed or, for zero, freezes everything. The stop condition freezes the state and suppresses output.

The bit-level mapping of codes and inverts needs the bench's scenarios. So do set storage and out-of-range indices, the point at which a set change lands, the exact count at which generation stops and resumes, and the long-run bit densities. The bench shows these against its own reference model.

// File: rtl/wprpg_pkg.sv
package wprpg_pkg;

   // random bits consumed per output bit
   localparam int GRP_W = 4;

   // AND of grp[0..code], optionally complemented
   function automatic logic bias_bit(input logic [GRP_W-1:0] grp,
                                     input logic [1:0]       code,
                                     input logic             inv);
      logic acc;
      acc = grp[0];
      for (int j = 1; j < GRP_W; j++) begin
         if (j <= int'(code)) acc = acc & grp[j];
      end
      return acc ^ inv;
   endfunction

endpackage

// File: rtl/wprpg_lfsr.sv
module wprpg_lfsr #(
   parameter int               W        = 32,
   parameter logic [W-1:0]     TAPS     = 32'h8020_0003,
   parameter logic [W-1:0]     RST_SEED = 32'h0000_0001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] state
);

   logic [W-1:0] nxt;

   always_comb begin
      nxt = state >> 1;
      if (state[0]) nxt = nxt ^ TAPS;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     state <= RST_SEED;
      else if (load)  state <= load_val;
      else if (step)  state <= nxt;
   end

endmodule

// File: rtl/wprpg_wbank.sv
module wprpg_wbank #(
   parameter int PAT_W    = 8,
   parameter int NUM_SETS = 3,
   parameter int SEL_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [SEL_W-1:0]   wr_set,
   input  logic [2*PAT_W-1:0] wr_code,
   input  logic [PAT_W-1:0]   wr_inv,
   input  logic [SEL_W-1:0]   rd_set,
   output logic [2*PAT_W-1:0] rd_code,
   output logic [PAT_W-1:0]   rd_inv
);

   localparam logic [SEL_W:0] NSETS_V = NUM_SETS[SEL_W:0];

   logic [2*PAT_W-1:0] code_q [NUM_SETS];
   logic [PAT_W-1:0]   inv_q  [NUM_SETS];
   logic [SEL_W-1:0]   rd_idx;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      localparam logic [SEL_W:0] IDX = s[SEL_W:0];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            code_q[s] <= '0;
            inv_q[s]  <= '0;
         end else if (we && ({1'b0, wr_set} == IDX)) begin
            code_q[s] <= wr_code;
            inv_q[s]  <= wr_inv;
         end
      end
   end

   // out-of-range selection falls back to set 0
   always_comb begin
      rd_idx  = ({1'b0, rd_set} < NSETS_V) ? rd_set : '0;
      rd_code = code_q[rd_idx];
      rd_inv  = inv_q[rd_idx];
   end

endmodule

// File: rtl/wprpg_bias.sv
module wprpg_bias
   import wprpg_pkg::*;
#(
   parameter int PAT_W  = 8,
   parameter int LFSR_W = 32
) (
   input  logic [LFSR_W-1:0]  state,
   input  logic [2*PAT_W-1:0] code,
   input  logic [PAT_W-1:0]   inv,
   output logic [PAT_W-1:0]   pat
);

   for (genvar i = 0; i < PAT_W; i++) begin : g_bit
      assign pat[i] = bias_bit(state[GRP_W*i +: GRP_W], code[2*i +: 2], inv[i]);
   end

endmodule

// File: rtl/wprpg_gen.sv
module wprpg_gen
   import wprpg_pkg::*;
#(
   parameter int                PAT_W      = 8,
   parameter int                LFSR_W     = 32,
   parameter logic [LFSR_W-1:0] LFSR_TAPS  = 32'h8020_0003,
   parameter logic [LFSR_W-1:0] RESET_SEED = 32'h0000_0001,
   parameter int                NUM_SETS   = 3,
   parameter int                CNT_W      = 16,
   localparam int               SEL_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               seed_load,
   input  logic [LFSR_W-1:0]  seed,
   input  logic               cfg_we,
   input  logic [SEL_W-1:0]   cfg_set,
   input  logic [2*PAT_W-1:0] cfg_code,
   input  logic [PAT_W-1:0]   cfg_inv,
   input  logic [SEL_W-1:0]   set_sel,
   input  logic [CNT_W-1:0]   pat_limit,
   output logic [PAT_W-1:0]   pattern,
   output logic               pat_valid,
   output logic               done
);

   // elaboration-time parameter checks
   if (LFSR_W < GRP_W * PAT_W) begin : g_bad_width
      $error("LFSR_W must cover GRP_W bits per pattern bit");
   end
   if (LFSR_TAPS[LFSR_W-1] !== 1'b1) begin : g_bad_taps
      $error("LFSR_TAPS must include the top term");
   end
   if (RESET_SEED == '0) begin : g_bad_seed
      $error("RESET_SEED must be nonzero");
   end
   if (NUM_SETS < 2 || NUM_SETS > 4) begin : g_bad_sets
      $error("NUM_SETS must lie in 2..4");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   logic [LFSR_W-1:0]  lfsr_q;
   logic [2*PAT_W-1:0] sel_code;
   logic [PAT_W-1:0]   sel_inv;
   logic [PAT_W-1:0]   biased;
   logic [CNT_W-1:0]   cnt_q;
   logic               seed_ok;
   logic               gen;

   assign seed_ok = seed_load && (seed != '0);
   assign done    = (pat_limit != '0) && (cnt_q >= pat_limit);
   assign gen     = en && !seed_load && !done;

   wprpg_lfsr #(
      .W        (LFSR_W),
      .TAPS     (LFSR_TAPS),
      .RST_SEED (RESET_SEED)
   ) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (seed_ok),
      .load_val (seed),
      .step     (gen),
      .state    (lfsr_q)
   );

   wprpg_wbank #(
      .PAT_W    (PAT_W),
      .NUM_SETS (NUM_SETS),
      .SEL_W    (SEL_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .wr_set   (cfg_set),
      .wr_code  (cfg_code),
      .wr_inv   (cfg_inv),
      .rd_set   (set_sel),
      .rd_code  (sel_code),
      .rd_inv   (sel_inv)
   );

   wprpg_bias #(
      .PAT_W  (PAT_W),
      .LFSR_W (LFSR_W)
   ) u_bias (
      .state (lfsr_q),
      .code  (sel_code),
      .inv   (sel_inv),
      .pat   (biased)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         pattern   <= '0;
         pat_valid <= 1'b0;
      end else begin
         pat_valid <= gen;
         if (gen) pattern <= biased;
         if (seed_ok)  cnt_q <= '0;
         else if (gen) cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wprpg_gen_chk.sv
module wprpg_gen_chk #(
   parameter int LFSR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              seed_load,
   input logic [LFSR_W-1:0] seed,
   input logic [LFSR_W-1:0] lfsr,
   input logic              pat_valid,
   input logic              done
);

   a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);

   a_r2_step_with_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      pat_valid |-> (lfsr != $past(lfsr)));

   a_r4_valid_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      pat_valid |-> $past(en));

   a_r3_zero_seed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed == '0) |=> ($stable(lfsr) && !pat_valid));

   a_r3_seed_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed != '0) |=> (lfsr == $past(seed) && !pat_valid && !done));

   a_r8_frozen_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !seed_load) |=> ($stable(lfsr) && !pat_valid));

endmodule

bind wprpg_gen wprpg_gen_chk #(.LFSR_W(LFSR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .seed_load (seed_load),
   .seed      (seed),
   .lfsr      (lfsr_q),
   .pat_valid (pat_valid),
   .done      (done)
);

// File: tb/sim_wprpg_gen.sv
module sim_wprpg_gen;

   localparam logic [31:0] TAPS = 32'h8020_0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        seed_load = 1'b0;
   logic [31:0] seed = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_set = '0;
   logic [15:0] cfg_code = '0;
   logic [7:0]  cfg_inv = '0;
   logic [1:0]  set_sel = '0;
   logic [15:0] pat_limit = '0;
   logic [7:0]  pattern;
   logic        pat_valid;
   logic        done;

   always #10 clk = ~clk;

   wprpg_gen u0 (
      .clk, .rst_n, .en, .seed_load, .seed, .cfg_we, .cfg_set, .cfg_code,
      .cfg_inv, .set_sel, .pat_limit, .pattern, .pat_valid, .done
   );

   int checks = 0;
   int errors = 0;
   int ones_acc = 0;
   logic [7:0] q[$];

   // reference state
   logic [31:0] m_lfsr = 32'h1;
   int          m_cnt = 0;
   logic [15:0] m_code [3] = '{default: '0};
   logic [7:0]  m_inv  [3] = '{default: '0};

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_pat(input logic [31:0] s,
                                          input logic [15:0] c,
                                          input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) begin
         int  k;
         logic b;
         k = int'(c[2*i +: 2]);
         b = 1'b1;
         for (int j = 0; j <= k; j++) b = b & s[4*i + j];
         r[i] = b ^ v[i];
      end
      return r;
   endfunction

   // monitor: pop expected item for every valid pattern (R4, R5, R7)
   always @(negedge clk) begin
      if (rst_n && pat_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R4", "unexpected pattern", {24'h0, pattern}, 32'h0);
         end else begin
            logic [7:0] e;
            e = q.pop_front();
            chk(pattern == e, "R4/R5/R7", "pattern", {24'h0, pattern}, {24'h0, e});
            ones_acc += $countones(pattern);
         end
      end
   end

   // driver: request n patterns, pushing what the rules predict
   task automatic gen(input int n);
      for (int p = 0; p < n; p++) begin
         @(negedge clk);
         en = 1'b1;
         if (!(pat_limit != 0 && m_cnt >= int'(pat_limit))) begin
            int s;
            s = (set_sel < 2'd3) ? int'(set_sel) : 0;
            q.push_back(exp_pat(m_lfsr, m_code[s], m_inv[s]));
            m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? TAPS : 32'h0);
            m_cnt++;
         end
      end
      @(negedge clk);
      en = 1'b0;
   endtask

   task automatic load_seed(input logic [31:0] v);
      @(negedge clk);
      seed_load = 1'b1;
      seed = v;
      en = 1'b1;
      @(negedge clk);
      seed_load = 1'b0;
      en = 1'b0;
      if (v != 0) begin
         m_lfsr = v;
         m_cnt = 0;
      end
   endtask

   task automatic wr_set(input logic [1:0] idx, input logic [15:0] c,
                         input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_set = idx;
      cfg_code = c;
      cfg_inv = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx < 2'd3) begin
         m_code[idx] = c;
         m_inv[idx] = v;
      end
   endtask

   task automatic drain(input string req);
      repeat (3) @(negedge clk);
      chk(q.size() == 0, req, "queue drained", q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1 reset state
      chk(pattern == 8'h0, "R1", "pattern in reset", {24'h0, pattern}, 0);
      chk(pat_valid == 1'b0, "R1", "valid in reset", {31'h0, pat_valid}, 0);
      chk(done == 1'b0, "R1", "done in reset", {31'h0, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pat_valid == 1'b0 && done == 1'b0, "R1", "idle after reset",
          {30'h0, pat_valid, done}, 0);

      // R1/R2/R4: default sets, sequence from RESET_SEED
      gen(4);
      drain("R2");

      // R6: configure sets, out-of-range write ignored
      wr_set(2'd1, 16'hE4E4, 8'hA5);
      wr_set(2'd2, 16'h5AF0, 8'h3C);
      wr_set(2'd3, 16'hFFFF, 8'hFF);
      set_sel = 2'd3;            // R7: falls back to set 0
      gen(3);
      drain("R6");

      // R7: switching sets mid-stream keeps the random sequence
      set_sel = 2'd1;
      gen(5);
      set_sel = 2'd2;
      gen(5);
      set_sel = 2'd1;
      gen(2);
      drain("R7");

      // R3: nonzero seed load, then zero seed ignored
      load_seed(32'hDEAD_BEEF);
      chk(pat_valid == 1'b0, "R3", "no pattern on seed cycle", {31'h0, pat_valid}, 0);
      gen(4);
      load_seed(32'h0);
      chk(pat_valid == 1'b0, "R3", "no pattern on zero seed", {31'h0, pat_valid}, 0);
      gen(4);
      drain("R3");

      // R8: limit of 5, extra requests ignored, then raise the limit
      pat_limit = 16'd5;
      load_seed(32'h1234_5678);
      chk(done == 1'b0, "R8", "done cleared by seed", {31'h0, done}, 0);
      gen(4);
      chk(done == 1'b0, "R8", "done after 4", {31'h0, done}, 0);
      gen(1);
      chk(done == 1'b1, "R8", "done after 5", {31'h0, done}, 1);
      gen(3);
      drain("R8");
      chk(done == 1'b1, "R8", "done held", {31'h0, done}, 1);
      pat_limit = 16'd7;
      @(negedge clk);
      chk(done == 1'b0, "R8", "resume on raised limit", {31'h0, done}, 0);
      gen(4);
      chk(done == 1'b1, "R8", "done at 7", {31'h0, done}, 1);
      drain("R8");

      // R9: limit 0 is unbounded
      pat_limit = 16'd0;
      @(negedge clk);
      chk(done == 1'b0, "R9", "done with limit 0", {31'h0, done}, 0);
      gen(20);
      chk(done == 1'b0, "R9", "still running", {31'h0, done}, 0);
      drain("R9");

      // R4/R5 densities: 1/16, 15/16, 1/4 and code 00 with invert at 1/2
      wr_set(2'd0, 16'hFFFF, 8'h00);
      wr_set(2'd1, 16'hFFFF, 8'hFF);
      wr_set(2'd2, 16'h5555, 8'h00);
      set_sel = 2'd0;
      ones_acc = 0;
      gen(1024);
      drain("R4");
      chk(ones_acc > 384 && ones_acc < 640, "R4", "density 1/16", ones_acc, 512);
      set_sel = 2'd1;
      ones_acc = 0;
      gen(1024);
      drain("R5");
      chk(ones_acc > 7552 && ones_acc < 7808, "R5", "density 15/16", ones_acc, 7680);
      set_sel = 2'd2;
      ones_acc = 0;
      gen(1024);
      drain("R4");
      chk(ones_acc > 1536 && ones_acc < 2560, "R4", "density 1/4", ones_acc, 2048);
      wr_set(2'd2, 16'h0000, 8'hFF);
      ones_acc = 0;
      gen(1024);
      drain("R5");
      chk(ones_acc > 3072 && ones_acc < 5120, "R5", "density 1/2 inverted", ones_acc, 4096);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule